// File: doc/BRIEF.md
# Tightly-Coupled Memory Region Router

This block sits between a processor core and its two private low-latency memories, one for instructions and one for data. For each memory, software programs a size register first and then a mapping register that carries the base address, a second copy of the size and an enable bit. From these settings the block works out which regions are live. It also flags any settings that break the rules: a base that is not aligned to its size, a size copy that disagrees with the size register, or two live regions that overlap.

Every cycle the block takes one instruction-fetch address and one load/store address. It routes each to the instruction memory, to the data memory, or to the system bus. The fetch port can only reach the instruction memory. The load/store port can reach either memory, so code can be copied into the instruction memory and constants stored there can be read back. For a memory hit the block also gives the offset inside the selected memory.

All outputs are registered, so each decision appears one clock after its request. A fetch or data access that falls inside a region that software enabled but that a configuration error has blocked goes to the system bus and raises that port's error flag.

Top module: `tcm_route_top`

## Requirements
- R1: After a synchronous active-high reset, both regions are inactive, `cfg_err` is 0, and every request goes to the system bus with no error.
- R2: A size code in bits [2:0] of a size register selects 4, 8, 16, 32 or 64 KB for codes 1 to 5, i.e. 2^(11+code) bytes. Code 0 and codes 6 and 7 leave the region inactive whatever its enable bit says.
- R3: `cfg_sel` picks the register that a write updates: 0 is the instruction size, 1 the data size, 2 the instruction map, 3 the data map. A map register holds enable in bit 0, a size copy in bits [3:1] and the base address in bits [31:12]. A region is active only while its enable bit is 1 and all of R5 to R7 pass.
- R4: An address hits an active region when it lies in [base, base+size). On a hit, the index output is the address modulo the region size.
- R5: An enabled region with a valid size whose base is not a multiple of its size sets `cfg_err` bit 0 (instruction) or bit 2 (data), and that region stays inactive.
- R6: An enabled region whose map size copy differs from its size register sets `cfg_err` bit 1 (instruction) or bit 3 (data), and that region stays inactive.
- R7: When both regions would otherwise be active and their address ranges intersect, `cfg_err` bit 4 is set and neither region is active. Regions that only touch do not count as overlapping.
- R8: The load/store port can be routed to the instruction memory as well as the data memory. The fetch port is only ever routed to the instruction memory or the system bus.
- R9: Each port's select, index, address and error outputs reflect the request from the previous clock. Exactly one select is high after a request, and all outputs are 0 after a cycle without one.
- R10: A request that goes to the bus and lies inside an enabled, validly sized region that is inactive because of R5, R6 or R7 raises that port's error output. The fetch port ignores the data region for this purpose.
- R11: The address output repeats the request address unchanged. The index is 0 whenever the bus is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (R3) |
| cfg_wdata | input | 32 | Register write data |
| if_req | input | 1 | Fetch request valid |
| if_addr | input | 32 | Fetch physical address |
| if_itcm | output | 1 | Fetch routed to instruction memory |
| if_bus | output | 1 | Fetch routed to system bus |
| if_idx | output | 16 | Offset inside the instruction memory |
| if_addr_o | output | 32 | Forwarded fetch address |
| if_err | output | 1 | Fetch hit a blocked region |
| dp_req | input | 1 | Load/store request valid |
| dp_addr | input | 32 | Load/store physical address |
| dp_itcm | output | 1 | Load/store routed to instruction memory |
| dp_dtcm | output | 1 | Load/store routed to data memory |
| dp_bus | output | 1 | Load/store routed to system bus |
| dp_idx | output | 16 | Offset inside the selected memory |
| dp_addr_o | output | 32 | Forwarded load/store address |
| dp_err | output | 1 | Load/store hit a blocked region |
| cfg_err | output | 5 | Configuration error flags (R5, R6, R7) |

## Verification
The assertions assume that request valids and addresses are known values whenever reset is low, and that reset is held at the first clock edge. Under that assumption the one-cycle routing properties stay well defined even when the configuration changes in the same cycle. The bench drives every input from time zero and changes inputs only on falling edges. It also keeps reset high for several cycles before any request or register write. Configuration writes happen while no request is outstanding, so each address sweep sees a settled configuration, and the expected route can be computed from range arithmetic alone.

// File: rtl/tcm_route_pkg.sv
package tcm_route_pkg;

  typedef enum logic [1:0] {
    SEL_ISIZE = 2'd0,
    SEL_DSIZE = 2'd1,
    SEL_IMAP  = 2'd2,
    SEL_DMAP  = 2'd3
  } cfg_sel_e;

  localparam int NUM_MEM = 2;
  localparam int MEM_I   = 0;
  localparam int MEM_D   = 1;

endpackage

// File: rtl/tcm_cfg_regs.sv
module tcm_cfg_regs
  import tcm_route_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int GRAN_LOG2 = 12,
  parameter int CODE_W    = 3
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   cfg_we,
  input  logic [1:0]                             cfg_sel,
  input  logic [ADDR_W-1:0]                      cfg_wdata,
  output logic [NUM_MEM-1:0][CODE_W-1:0]         size_code,
  output logic [NUM_MEM-1:0]                     map_en,
  output logic [NUM_MEM-1:0][CODE_W-1:0]         map_code,
  output logic [NUM_MEM-1:0][ADDR_W-GRAN_LOG2-1:0] map_base
);
  localparam int GRAN_W = ADDR_W - GRAN_LOG2;

  logic unused_wdata_bits;
  assign unused_wdata_bits = ^cfg_wdata[GRAN_LOG2-1:CODE_W+1];

  for (genvar m = 0; m < NUM_MEM; m++) begin : g_mem
    localparam logic [1:0] SIZE_SEL = (m == MEM_I) ? SEL_ISIZE : SEL_DSIZE;
    localparam logic [1:0] MAP_SEL  = (m == MEM_I) ? SEL_IMAP  : SEL_DMAP;

    always_ff @(posedge clk) begin
      if (rst) begin
        size_code[m] <= '0;
        map_en[m]    <= 1'b0;
        map_code[m]  <= '0;
        map_base[m]  <= '0;
      end else if (cfg_we) begin
        if (cfg_sel == SIZE_SEL) begin
          size_code[m] <= cfg_wdata[CODE_W-1:0];
        end
        if (cfg_sel == MAP_SEL) begin
          map_en[m]   <= cfg_wdata[0];
          map_code[m] <= cfg_wdata[CODE_W:1];
          map_base[m] <= cfg_wdata[ADDR_W-1:GRAN_LOG2];
        end
      end
    end

    // R1: registers come out of reset cleared
    a_r1_reset_clear: assert property (@(posedge clk)
      rst |=> (map_en[m] == 1'b0 && size_code[m] == '0));

    logic [GRAN_W-1:0] unused_w;
    assign unused_w = '0;
  end

endmodule

// File: rtl/tcm_region_check.sv
module tcm_region_check #(
  parameter int ADDR_W    = 32,
  parameter int GRAN_LOG2 = 12,
  parameter int CODE_W    = 3,
  parameter int MAX_CODE  = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [CODE_W-1:0]             size_code,
  input  logic                          map_en,
  input  logic [CODE_W-1:0]             map_code,
  input  logic [ADDR_W-GRAN_LOG2-1:0]   map_base,
  output logic                          armed,
  output logic                          valid,
  output logic                          misalign,
  output logic                          mismatch,
  output logic [ADDR_W-GRAN_LOG2-1:0]   low_mask
);
  localparam int GRAN_W = ADDR_W - GRAN_LOG2;

  logic size_ok;

  assign size_ok = (size_code != '0) && (int'(size_code) <= MAX_CODE);

  // granule bits that sit below the region size
  always_comb begin
    for (int b = 0; b < GRAN_W; b++) begin
      low_mask[b] = size_ok && (b < int'(size_code) - 1);
    end
  end

  assign armed    = map_en && size_ok;
  assign mismatch = map_en && (map_code != size_code);
  assign misalign = armed && ((map_base & low_mask) != '0);
  assign valid    = armed && !mismatch && !misalign;

  // R2: a region with an unusable size is never valid
  a_r2_bad_size_idle: assert property (@(posedge clk) disable iff (rst)
    (size_code == '0 || int'(size_code) > MAX_CODE) |-> !valid);

  // R5: a flagged misaligned region is never valid
  a_r5_misalign_idle: assert property (@(posedge clk) disable iff (rst)
    misalign |-> !valid);

endmodule

// File: rtl/tcm_port_route.sv
module tcm_port_route #(
  parameter int ADDR_W     = 32,
  parameter int GRAN_LOG2  = 12,
  parameter int MAX_CODE   = 5,
  parameter bit ALLOW_DTCM = 1'b1
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     req,
  input  logic [ADDR_W-1:0]                        addr,
  input  logic                                     act_i,
  input  logic                                     act_d,
  input  logic                                     armed_i,
  input  logic                                     armed_d,
  input  logic [ADDR_W-GRAN_LOG2-1:0]              base_i,
  input  logic [ADDR_W-GRAN_LOG2-1:0]              base_d,
  input  logic [ADDR_W-GRAN_LOG2-1:0]              lowm_i,
  input  logic [ADDR_W-GRAN_LOG2-1:0]              lowm_d,
  output logic                                     sel_itcm,
  output logic                                     sel_dtcm,
  output logic                                     sel_bus,
  output logic [GRAN_LOG2+MAX_CODE-2:0]            idx,
  output logic [ADDR_W-1:0]                        addr_o,
  output logic                                     err
);
  localparam int GRAN_W = ADDR_W - GRAN_LOG2;
  localparam int IDX_W  = GRAN_LOG2 + MAX_CODE - 1;

  logic [GRAN_W-1:0] addr_g;
  logic              in_i, in_d;
  logic              hit_i, hit_d;
  logic              blocked;
  logic [ADDR_W-1:0] mask_i, mask_d, off_full;

  assign addr_g = addr[ADDR_W-1:GRAN_LOG2];

  assign in_i  = armed_i && (((addr_g ^ base_i) & ~lowm_i) == '0);
  assign hit_i = act_i && in_i;

  if (ALLOW_DTCM) begin : g_dside
    assign in_d  = armed_d && (((addr_g ^ base_d) & ~lowm_d) == '0);
    assign hit_d = act_d && in_d && !hit_i;
  end else begin : g_iside
    logic unused_dside;
    assign unused_dside = ^{act_d, armed_d, base_d, lowm_d};
    assign in_d  = 1'b0;
    assign hit_d = 1'b0;
  end

  assign blocked = (in_i && !act_i) || (in_d && !act_d);

  assign mask_i = {lowm_i, {GRAN_LOG2{1'b1}}};
  assign mask_d = {lowm_d, {GRAN_LOG2{1'b1}}};

  always_comb begin
    if (hit_i)      off_full = addr & mask_i;
    else if (hit_d) off_full = addr & mask_d;
    else            off_full = '0;
  end

  logic unused_off;
  assign unused_off = ^off_full[ADDR_W-1:IDX_W];

  always_ff @(posedge clk) begin
    if (rst || !req) begin
      sel_itcm <= 1'b0;
      sel_dtcm <= 1'b0;
      sel_bus  <= 1'b0;
      idx      <= '0;
      addr_o   <= '0;
      err      <= 1'b0;
    end else begin
      sel_itcm <= hit_i;
      sel_dtcm <= hit_d;
      sel_bus  <= !(hit_i || hit_d);
      idx      <= off_full[IDX_W-1:0];
      addr_o   <= addr;
      err      <= !(hit_i || hit_d) && blocked;
    end
  end

  // R9: at most one destination at a time
  a_r9_one_route: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel_itcm, sel_dtcm, sel_bus}));

  // R9: a request always produces a route one cycle later
  a_r9_req_routed: assert property (@(posedge clk) disable iff (rst)
    req |=> (sel_itcm || sel_dtcm || sel_bus));

  // R9: no request, no activity
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !req |=> !(sel_itcm || sel_dtcm || sel_bus || err));

  // R11: forwarded address is the request address
  a_r11_addr_fwd: assert property (@(posedge clk) disable iff (rst)
    req |=> (addr_o == $past(addr)));

  // R11: bus route carries no index
  a_r11_bus_idx: assert property (@(posedge clk) disable iff (rst)
    sel_bus |-> (idx == '0));

  // R10: an error is only reported on a bus route
  a_r10_err_on_bus: assert property (@(posedge clk) disable iff (rst)
    err |-> sel_bus);

endmodule

// File: rtl/tcm_route_top.sv
module tcm_route_top
  import tcm_route_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int GRAN_LOG2 = 12,
  parameter int CODE_W    = 3,
  parameter int MAX_CODE  = 5,
  localparam int IDX_W    = GRAN_LOG2 + MAX_CODE - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              if_req,
  input  logic [ADDR_W-1:0] if_addr,
  output logic              if_itcm,
  output logic              if_bus,
  output logic [IDX_W-1:0]  if_idx,
  output logic [ADDR_W-1:0] if_addr_o,
  output logic              if_err,
  input  logic              dp_req,
  input  logic [ADDR_W-1:0] dp_addr,
  output logic              dp_itcm,
  output logic              dp_dtcm,
  output logic              dp_bus,
  output logic [IDX_W-1:0]  dp_idx,
  output logic [ADDR_W-1:0] dp_addr_o,
  output logic              dp_err,
  output logic [4:0]        cfg_err
);
  localparam int GRAN_W = ADDR_W - GRAN_LOG2;

  logic [NUM_MEM-1:0][CODE_W-1:0] size_code;
  logic [NUM_MEM-1:0]             map_en;
  logic [NUM_MEM-1:0][CODE_W-1:0] map_code;
  logic [NUM_MEM-1:0][GRAN_W-1:0] map_base;

  logic [NUM_MEM-1:0]             armed, valid, misalign, mismatch, active;
  logic [NUM_MEM-1:0][GRAN_W-1:0] low_mask;
  logic                           overlap;

  tcm_cfg_regs #(
    .ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2), .CODE_W(CODE_W)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .size_code(size_code), .map_en(map_en),
    .map_code(map_code), .map_base(map_base)
  );

  for (genvar m = 0; m < NUM_MEM; m++) begin : g_chk
    tcm_region_check #(
      .ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2), .CODE_W(CODE_W),
      .MAX_CODE(MAX_CODE)
    ) u_chk (
      .clk(clk), .rst(rst),
      .size_code(size_code[m]), .map_en(map_en[m]),
      .map_code(map_code[m]), .map_base(map_base[m]),
      .armed(armed[m]), .valid(valid[m]), .misalign(misalign[m]),
      .mismatch(mismatch[m]), .low_mask(low_mask[m])
    );
    assign active[m] = valid[m] && !overlap;
  end

  // aligned power-of-two regions intersect exactly when they agree
  // on every granule bit above the larger of the two sizes
  assign overlap = valid[MEM_I] && valid[MEM_D] &&
    (((map_base[MEM_I] ^ map_base[MEM_D]) &
      ~(low_mask[MEM_I] | low_mask[MEM_D])) == '0);

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= '0;
    else     cfg_err <= {overlap, mismatch[MEM_D], misalign[MEM_D],
                         mismatch[MEM_I], misalign[MEM_I]};
  end

  logic if_dtcm_nc;

  tcm_port_route #(
    .ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2), .MAX_CODE(MAX_CODE),
    .ALLOW_DTCM(1'b0)
  ) u_fetch (
    .clk(clk), .rst(rst), .req(if_req), .addr(if_addr),
    .act_i(active[MEM_I]), .act_d(active[MEM_D]),
    .armed_i(armed[MEM_I]), .armed_d(armed[MEM_D]),
    .base_i(map_base[MEM_I]), .base_d(map_base[MEM_D]),
    .lowm_i(low_mask[MEM_I]), .lowm_d(low_mask[MEM_D]),
    .sel_itcm(if_itcm), .sel_dtcm(if_dtcm_nc), .sel_bus(if_bus),
    .idx(if_idx), .addr_o(if_addr_o), .err(if_err)
  );

  logic unused_fetch;
  assign unused_fetch = if_dtcm_nc;

  tcm_port_route #(
    .ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2), .MAX_CODE(MAX_CODE),
    .ALLOW_DTCM(1'b1)
  ) u_data (
    .clk(clk), .rst(rst), .req(dp_req), .addr(dp_addr),
    .act_i(active[MEM_I]), .act_d(active[MEM_D]),
    .armed_i(armed[MEM_I]), .armed_d(armed[MEM_D]),
    .base_i(map_base[MEM_I]), .base_d(map_base[MEM_D]),
    .lowm_i(low_mask[MEM_I]), .lowm_d(low_mask[MEM_D]),
    .sel_itcm(dp_itcm), .sel_dtcm(dp_dtcm), .sel_bus(dp_bus),
    .idx(dp_idx), .addr_o(dp_addr_o), .err(dp_err)
  );

  // R7: overlapping regions block both memories on the data port
  a_r7_overlap_blocks: assert property (@(posedge clk) disable iff (rst)
    (overlap && dp_req) |=> (!dp_itcm && !dp_dtcm));

  // R6: mismatched data region never receives a load/store
  a_r6_mismatch_blocks: assert property (@(posedge clk) disable iff (rst)
    (mismatch[MEM_D] && dp_req) |=> !dp_dtcm);

  // R5: misaligned instruction region never receives a fetch
  a_r5_misalign_blocks: assert property (@(posedge clk) disable iff (rst)
    (misalign[MEM_I] && if_req) |=> !if_itcm);

  // R8: fetch side never reaches the data memory
  a_r8_fetch_no_dtcm: assert property (@(posedge clk) disable iff (rst)
    !if_dtcm_nc);

  // R1: error flags are clear right after reset
  a_r1_err_reset: assert property (@(posedge clk)
    rst |=> (cfg_err == '0));

endmodule

// File: tb/test_tcm_route_top.sv
`timescale 1ns/1ps
module test_tcm_route_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        if_req = 1'b0;
  logic [31:0] if_addr = '0;
  logic        dp_req = 1'b0;
  logic [31:0] dp_addr = '0;
  logic        if_itcm, if_bus, if_err;
  logic [15:0] if_idx;
  logic [31:0] if_addr_o;
  logic        dp_itcm, dp_dtcm, dp_bus, dp_err;
  logic [15:0] dp_idx;
  logic [31:0] dp_addr_o;
  logic [4:0]  cfg_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  tcm_route_top i_tcm_route_top (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata),
    .if_req(if_req), .if_addr(if_addr), .if_itcm(if_itcm), .if_bus(if_bus),
    .if_idx(if_idx), .if_addr_o(if_addr_o), .if_err(if_err),
    .dp_req(dp_req), .dp_addr(dp_addr), .dp_itcm(dp_itcm),
    .dp_dtcm(dp_dtcm), .dp_bus(dp_bus), .dp_idx(dp_idx),
    .dp_addr_o(dp_addr_o), .dp_err(dp_err), .cfg_err(cfg_err)
  );

  // configuration as seen by the model
  int     c_isz, c_dsz, c_imc, c_dmc;
  bit     c_ien, c_den;
  longint c_ib, c_db;
  // derived expectations
  bit     g_arm_i, g_arm_d, g_act_i, g_act_d;
  bit     g_mal_i, g_mal_d, g_mis_i, g_mis_d, g_ov;
  longint g_si, g_sd, g_bi, g_bd;

  task automatic chk(string req, longint act, longint exp, string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic bit size_ok(int c);
    return (c >= 1) && (c <= 5);
  endfunction

  function automatic longint bytes_of(int c);
    return size_ok(c) ? (longint'(1) << (11 + c)) : longint'(4096);
  endfunction

  function automatic void model_eval();
    bit ok_i, ok_d;
    g_bi = bytes_of(c_isz);
    g_bd = bytes_of(c_dsz);
    g_si = c_ib - (c_ib % g_bi);
    g_sd = c_db - (c_db % g_bd);
    g_arm_i = c_ien && size_ok(c_isz);
    g_arm_d = c_den && size_ok(c_dsz);
    g_mis_i = c_ien && (c_imc != c_isz);
    g_mis_d = c_den && (c_dmc != c_dsz);
    g_mal_i = g_arm_i && (c_ib % g_bi != 0);
    g_mal_d = g_arm_d && (c_db % g_bd != 0);
    ok_i = g_arm_i && !g_mis_i && !g_mal_i;
    ok_d = g_arm_d && !g_mis_d && !g_mal_d;
    g_ov = ok_i && ok_d && (g_si < g_sd + g_bd) && (g_sd < g_si + g_bi);
    g_act_i = ok_i && !g_ov;
    g_act_d = ok_d && !g_ov;
  endfunction

  task automatic wr(logic [1:0] sel, logic [31:0] data);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // R2 R3 R5 R6 R7: program both regions and check the error flags
  task automatic setup(string tag, int isz, int imc, bit ien, longint ib,
                       int dsz, int dmc, bit den, longint db);
    c_isz = isz; c_imc = imc; c_ien = ien; c_ib = ib;
    c_dsz = dsz; c_dmc = dmc; c_den = den; c_db = db;
    wr(2'd0, 32'(isz));
    wr(2'd1, 32'(dsz));
    wr(2'd2, {ib[31:12], 8'h00, imc[2:0], ien});
    wr(2'd3, {db[31:12], 8'h00, dmc[2:0], den});
    @(negedge clk);
    model_eval();
    chk(tag, longint'(cfg_err),
        longint'({g_ov, g_mis_d, g_mal_d, g_mis_i, g_mal_i}), "cfg_err");
  endtask

  task automatic access(string tag, bit req, logic [31:0] a);
    longint ax;
    bit in_i, in_d, e_ii, e_ib, e_ie, e_di, e_dd, e_db, e_de;
    longint e_iidx, e_didx;
    if_req = req; dp_req = req; if_addr = a; dp_addr = a;
    @(negedge clk);
    ax = longint'({32'd0, a});
    in_i = g_arm_i && ax >= g_si && ax < g_si + g_bi;
    in_d = g_arm_d && ax >= g_sd && ax < g_sd + g_bd;
    e_ii = req && g_act_i && in_i;
    e_ib = req && !e_ii;
    e_ie = e_ib && in_i && !g_act_i;
    e_iidx = e_ii ? ax - g_si : 0;
    e_di = req && g_act_i && in_i;
    e_dd = req && !e_di && g_act_d && in_d;
    e_db = req && !(e_di || e_dd);
    e_de = e_db && ((in_i && !g_act_i) || (in_d && !g_act_d));
    e_didx = e_di ? ax - g_si : (e_dd ? ax - g_sd : 0);
    if (!req) begin
      chk("R9", longint'({if_itcm, if_bus, if_err, dp_itcm, dp_dtcm,
                          dp_bus, dp_err}), 0, "idle outputs");
      chk("R9", longint'(if_addr_o) + longint'(dp_addr_o), 0, "idle address");
    end else begin
      chk((in_d && !in_i) ? "R8" : tag,
          longint'({if_itcm, if_bus}), longint'({e_ii, e_ib}), "fetch route");
      chk(e_di ? "R8" : tag, longint'({dp_itcm, dp_dtcm, dp_bus}),
          longint'({e_di, e_dd, e_db}), "data route");
      chk("R10", longint'({if_err, dp_err}), longint'({e_ie, e_de}), "port errors");
      chk("R4", longint'(if_idx), e_iidx, "fetch index");
      chk("R4", longint'(dp_idx), e_didx, "data index");
      chk("R11", longint'(if_addr_o), ax, "fetch address out");
      chk("R11", longint'(dp_addr_o), ax, "data address out");
    end
  endtask

  task automatic sweep(string tag, longint centre);
    for (int k = -8; k < 72; k++) begin
      longint a;
      a = centre + longint'(k) * 1024 + longint'((k & 3) * 4);
      access(tag, (k % 9) != 0, a[31:0]);
    end
  endtask

  task automatic run(string tag, int isz, int imc, bit ien, longint ib,
                     int dsz, int dmc, bit den, longint db);
    setup(tag, isz, imc, ien, ib, dsz, dmc, den, db);
    sweep(tag, ib);
    sweep(tag, db);
    if_req = 1'b0; dp_req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    c_isz = 0; c_dsz = 0; c_imc = 0; c_dmc = 0;
    c_ien = 0; c_den = 0; c_ib = 0; c_db = 0;
    model_eval();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", longint'(cfg_err), 0, "cfg_err after reset");
    chk("R1", longint'({if_itcm, if_bus, dp_itcm, dp_dtcm, dp_bus}), 0,
        "selects after reset");
    access("R1", 1'b1, 32'h0010_0000);
    access("R1", 1'b1, 32'h0000_0000);
    // R3: enable bit clear keeps regions inactive
    run("R3", 3, 3, 1'b0, 64'h0010_0000, 2, 2, 1'b0, 64'h0020_0000);
    // R4: both regions live, disjoint
    run("R4", 3, 3, 1'b1, 64'h0010_0000, 2, 2, 1'b1, 64'h0020_0000);
    // R5: misaligned instruction base
    run("R5", 3, 3, 1'b1, 64'h0010_1000, 2, 2, 1'b1, 64'h0020_0000);
    // R5: misaligned data base
    run("R5", 1, 1, 1'b1, 64'h0010_0000, 4, 4, 1'b1, 64'h0020_4000);
    // R6: data size copy disagrees
    run("R6", 3, 3, 1'b1, 64'h0010_0000, 2, 3, 1'b1, 64'h0020_0000);
    // R6: instruction size copy disagrees
    run("R6", 2, 5, 1'b1, 64'h0010_0000, 2, 2, 1'b1, 64'h0020_0000);
    // R7: data region inside instruction region
    run("R7", 3, 3, 1'b1, 64'h0010_0000, 2, 2, 1'b1, 64'h0010_2000);
    // R7: adjacent regions are fine
    run("R7", 1, 1, 1'b1, 64'h0050_0000, 1, 1, 1'b1, 64'h0050_1000);
    // R2: size 0 with enable, and an out-of-range code
    run("R2", 0, 0, 1'b1, 64'h0010_0000, 6, 6, 1'b1, 64'h0020_0000);
    // R2: largest size on both sides
    run("R2", 5, 5, 1'b1, 64'h0030_0000, 5, 5, 1'b1, 64'h0040_0000);
    // R2: every legal size for the instruction region
    for (int c = 1; c <= 5; c++) begin
      run("R2", c, c, 1'b1, 64'h0060_0000, 1, 1, 1'b1, 64'h0070_0000);
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule